// File: doc/BRIEF.md
# Display Power-Up Sequencer

This block brings an SPI-attached panel controller from reset to a running state and then services power-on and power-off requests. It never drives the serial wires itself. It issues one register operation at a time to a separate register access engine and waits for that engine's completion strobe before it moves on. The operation is a register read, a register write, or a write of the index register alone.

After reset the block reads register 0x00 and keeps the controller only if the upper twelve bits of the returned word match 0x922. On a mismatch it raises a not-found flag and stops for good. On a match it works through a fixed step list held in a small internal ROM:
- start the oscillator;
- pick the RGB pixel interface;
- run the full power-on sequence;
- select the graphics RAM data register.

Some steps are timed pauses. A millisecond tick, derived from the system clock through a clocks-per-millisecond parameter, counts these pauses.

Once the block is idle, a power request runs the on or off sequence, but only when that request actually changes the stored power state. A request that arrives while a sequence is running is held and evaluated when that sequence finishes.

Top module: `dpwr_seq_top`

## Requirements
- R1: During and right after reset, `busy` is 1 and `present`, `not_found` and `pwr_on` are 0. The first engine operation is a read (op code 2'b10) of register 0x00.
- R2: The device is accepted (`present` = 1) exactly when (read word AND 0xFFF0) equals 0x9220.
- R3: On a rejected ID, `not_found` rises and `busy` falls. No further engine operation is issued, and later power requests have no effect.
- R4: After acceptance, the engine operations come in this order. First a register write (op 2'b01) of 0x0001 to 0x00, followed by a wait of 10 ms. Next a write of 0x0110 to 0x0C. Then the whole R8 sequence. Last, an index-only write (op 2'b00) of 0x22 with data 0. The block then ends with `pwr_on` = 1 and `busy` = 0.
- R5: `eng_req` stays high with stable op, address and data until `eng_done` is sampled high. It is low on the following cycle.
- R6: Every timed wait of N ms separates the completion of the preceding operation from the next request, or from the fall of `busy`, by at least N × CLKS_PER_MS cycles.
- R7: The off sequence is four register writes, all with data 0x0000. It writes 0x10, waits 10 ms, writes 0x11 and then 0x12, waits 40 ms, writes 0x13, and waits 40 ms.
- R8: The on sequence first performs the whole R7 sequence. It then writes 0x080F to 0x56 and 0x4240 to 0x10, and waits 10 ms. Next it writes 0x0000 to 0x11 and 0x0014 to 0x12, and waits 40 ms. Finally it writes 0x1319 to 0x13 and waits 40 ms.
- R9: A request for on while `pwr_on` = 1, or for off while `pwr_on` = 0, issues no engine operation and leaves `busy` low.
- R10: `pwr_on` changes only at the end of a completed sequence, in the same cycle that `busy` falls.
- R11: A request made while `busy` is 1 is held and evaluated after the running sequence or the initialisation ends. A later request replaces an earlier one still held.
- R12: `busy` is 1 whenever an engine operation is outstanding or a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | One-cycle power request strobe |
| pwr_req_on | input | 1 | Requested state with the strobe: 1 on, 0 off |
| eng_req | output | 1 | Operation request to the register access engine |
| eng_op | output | 2 | 2'b00 index-only write, 2'b01 register write, 2'b10 register read |
| eng_addr | output | 8 | Register index |
| eng_wdata | output | 16 | Register write value |
| eng_done | input | 1 | Engine completion strobe |
| eng_rdata | input | 16 | Read word, valid with `eng_done` |
| busy | output | 1 | Sequence or probe in progress |
| present | output | 1 | Controller ID accepted |
| not_found | output | 1 | Controller ID rejected, block halted |
| pwr_on | output | 1 | Stored panel power state |

## Verification
The bound checker watches the engine handshake (R5) on every cycle. It also checks that `pwr_on` moves only as `busy` falls (R10), that requests happen only while busy (R12), and that a halted block stays silent with its flags locked (R2, R3). The exact ordering and contents of the write lists, the lower bound on each timed pause, the skipping of redundant requests and the holding of late requests can only be seen in the bench scenarios. The bench sweeps all sixteen accepted ID values and a set of near-miss rejected IDs, and then runs the power transitions, including back-to-back and superseded requests.

// File: rtl/dpwr_pkg.sv
package dpwr_pkg;

  localparam int REG_AW  = 8;
  localparam int REG_DW  = 16;
  localparam int STEP_AW = 6;

  localparam logic [REG_DW-1:0] ID_MASK  = 16'hFFF0;
  localparam logic [REG_DW-1:0] ID_MATCH = 16'h9220;

  // step list layout; entry order is the required write order
  localparam logic [STEP_AW-1:0] ON_BASE   = 6'd0;
  localparam logic [STEP_AW-1:0] OFF_BASE  = 6'd16;
  localparam logic [STEP_AW-1:0] INIT_BASE = 6'd24;

  typedef enum logic [1:0] {
    OP_IDX  = 2'b00,
    OP_WREG = 2'b01,
    OP_READ = 2'b10
  } eng_op_e;

  typedef enum logic [1:0] {
    K_WRITE,
    K_INDEX,
    K_WAIT,
    K_END
  } step_kind_e;

  typedef struct packed {
    step_kind_e        kind;
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
  } step_t;

  function automatic step_t mk_step(step_kind_e k, logic [REG_AW-1:0] a,
                                    logic [REG_DW-1:0] d);
    step_t s;
    s.kind = k;
    s.addr = a;
    s.data = d;
    return s;
  endfunction

  // shared power-down portion
  function automatic step_t off_step(int unsigned i);
    case (i)
      0:       return mk_step(K_WRITE, 8'h10, 16'h0000);
      1:       return mk_step(K_WAIT,  8'h00, 16'd10);
      2:       return mk_step(K_WRITE, 8'h11, 16'h0000);
      3:       return mk_step(K_WRITE, 8'h12, 16'h0000);
      4:       return mk_step(K_WAIT,  8'h00, 16'd40);
      5:       return mk_step(K_WRITE, 8'h13, 16'h0000);
      default: return mk_step(K_WAIT,  8'h00, 16'd40);
    endcase
  endfunction

  // power-up portion that follows the power-down portion
  function automatic step_t on_tail(int unsigned i);
    case (i)
      0:       return mk_step(K_WRITE, 8'h56, 16'h080F);
      1:       return mk_step(K_WRITE, 8'h10, 16'h4240);
      2:       return mk_step(K_WAIT,  8'h00, 16'd10);
      3:       return mk_step(K_WRITE, 8'h11, 16'h0000);
      4:       return mk_step(K_WRITE, 8'h12, 16'h0014);
      5:       return mk_step(K_WAIT,  8'h00, 16'd40);
      6:       return mk_step(K_WRITE, 8'h13, 16'h1319);
      default: return mk_step(K_WAIT,  8'h00, 16'd40);
    endcase
  endfunction

  function automatic step_t step_at(logic [STEP_AW-1:0] a);
    int unsigned i;
    i = int'(a);
    if (i < 7)        return off_step(i);
    else if (i < 15)  return on_tail(i - 7);
    else if (i == 15) return mk_step(K_END, 8'h00, 16'h0000);
    else if (i < 23)  return off_step(i - 16);
    else if (i == 23) return mk_step(K_END, 8'h00, 16'h0000);
    else if (i == 24) return mk_step(K_WRITE, 8'h00, 16'h0001);
    else if (i == 25) return mk_step(K_WAIT,  8'h00, 16'd10);
    else if (i == 26) return mk_step(K_WRITE, 8'h0C, 16'h0110);
    else if (i < 34)  return off_step(i - 27);
    else if (i < 42)  return on_tail(i - 34);
    else if (i == 42) return mk_step(K_INDEX, 8'h22, 16'h0000);
    else              return mk_step(K_END, 8'h00, 16'h0000);
  endfunction

endpackage

// File: rtl/dpwr_ms_tick.sv
module dpwr_ms_tick #(
  parameter int unsigned CLKS_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0] cnt;

  // clr restarts the phase so a wait never starts mid-millisecond
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dpwr_wait_timer.sv
module dpwr_wait_timer #(
  parameter int unsigned MS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [MS_W-1:0] load_ms,
  input  logic            tick,
  output logic            expire
);
  logic [MS_W-1:0] remain;
  logic            running;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      running <= 1'b0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (start) begin
        if (load_ms == '0) begin
          running <= 1'b0;
          expire  <= 1'b1;
        end else begin
          remain  <= load_ms;
          running <= 1'b1;
        end
      end else if (running && tick) begin
        if (remain == MS_W'(1)) begin
          running <= 1'b0;
          expire  <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dpwr_step_rom.sv
module dpwr_step_rom
  import dpwr_pkg::*;
(
  input  logic               clk,
  input  logic [STEP_AW-1:0] addr,
  output step_t              q
);
  // registered read keeps the step list mappable to a block RAM
  always_ff @(posedge clk) begin
    q <= step_at(addr);
  end
endmodule

// File: rtl/dpwr_seq_top.sv
module dpwr_seq_top
  import dpwr_pkg::*;
#(
  parameter int unsigned CLKS_PER_MS = 100000,
  parameter int unsigned MS_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_req,
  input  logic              pwr_req_on,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [REG_AW-1:0] eng_addr,
  output logic [REG_DW-1:0] eng_wdata,
  input  logic              eng_done,
  input  logic [REG_DW-1:0] eng_rdata,
  output logic              busy,
  output logic              present,
  output logic              not_found,
  output logic              pwr_on
);
  typedef enum logic [2:0] {
    S_PROBE, S_PWAIT, S_FETCH, S_DECODE, S_ENG, S_TIMER, S_IDLE, S_HALT
  } fsm_e;

  fsm_e               st;
  logic [STEP_AW-1:0] pc;
  step_t              rom_q;
  logic               target_on;
  logic               pend_vld;
  logic               pend_on;
  logic               tmr_start;
  logic               tick;
  logic               expire;
  logic               id_ok;

  assign tmr_start = (st == S_DECODE) && (rom_q.kind == K_WAIT);
  assign id_ok     = ((eng_rdata & ID_MASK) == ID_MATCH);

  dpwr_step_rom rom_i (
    .clk  (clk),
    .addr (pc),
    .q    (rom_q)
  );

  dpwr_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (tmr_start),
    .tick (tick)
  );

  dpwr_wait_timer #(.MS_W(MS_W)) tmr_i (
    .clk     (clk),
    .rst     (rst),
    .start   (tmr_start),
    .load_ms (rom_q.data[MS_W-1:0]),
    .tick    (tick),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_PROBE;
      pc        <= INIT_BASE;
      target_on <= 1'b1;
      pend_vld  <= 1'b0;
      pend_on   <= 1'b0;
      eng_req   <= 1'b0;
      eng_op    <= OP_READ;
      eng_addr  <= '0;
      eng_wdata <= '0;
      busy      <= 1'b1;
      present   <= 1'b0;
      not_found <= 1'b0;
      pwr_on    <= 1'b0;
    end else begin
      case (st)
        S_PROBE: begin
          eng_req   <= 1'b1;
          eng_op    <= OP_READ;
          eng_addr  <= 8'h00;
          eng_wdata <= '0;
          st        <= S_PWAIT;
        end
        S_PWAIT: begin
          if (eng_done) begin
            eng_req <= 1'b0;
            if (id_ok) begin
              present   <= 1'b1;
              pc        <= INIT_BASE;
              target_on <= 1'b1;
              st        <= S_FETCH;
            end else begin
              not_found <= 1'b1;
              busy      <= 1'b0;
              st        <= S_HALT;
            end
          end
        end
        S_FETCH: st <= S_DECODE;
        S_DECODE: begin
          case (rom_q.kind)
            K_WRITE: begin
              eng_req   <= 1'b1;
              eng_op    <= OP_WREG;
              eng_addr  <= rom_q.addr;
              eng_wdata <= rom_q.data;
              st        <= S_ENG;
            end
            K_INDEX: begin
              eng_req   <= 1'b1;
              eng_op    <= OP_IDX;
              eng_addr  <= rom_q.addr;
              eng_wdata <= '0;
              st        <= S_ENG;
            end
            K_WAIT: st <= S_TIMER;
            default: begin
              pwr_on <= target_on;
              busy   <= 1'b0;
              st     <= S_IDLE;
            end
          endcase
        end
        S_ENG: begin
          if (eng_done) begin
            eng_req <= 1'b0;
            pc      <= pc + 1'b1;
            st      <= S_FETCH;
          end
        end
        S_TIMER: begin
          if (expire) begin
            pc <= pc + 1'b1;
            st <= S_FETCH;
          end
        end
        S_IDLE: begin
          if (pend_vld) begin
            pend_vld <= 1'b0;
            if (pend_on != pwr_on) begin
              target_on <= pend_on;
              pc        <= pend_on ? ON_BASE : OFF_BASE;
              busy      <= 1'b1;
              st        <= S_FETCH;
            end
          end
        end
        default: st <= S_HALT;
      endcase

      // a fresh request overrides any held one, including one consumed now
      if (pwr_req && (st != S_HALT)) begin
        pend_vld <= 1'b1;
        pend_on  <= pwr_req_on;
      end
    end
  end
endmodule

// File: rtl/dpwr_seq_chk.sv
module dpwr_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        eng_req,
  input logic [1:0]  eng_op,
  input logic [7:0]  eng_addr,
  input logic [15:0] eng_wdata,
  input logic        eng_done,
  input logic        busy,
  input logic        present,
  input logic        not_found,
  input logic        pwr_on
);
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) &&
                                $stable(eng_addr) && $stable(eng_wdata)));

  a_r5_req_drop: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_done) |=> !eng_req);

  a_r3_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    not_found |-> (!eng_req && !busy && !pwr_on));

  a_r3_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    not_found |=> not_found);

  a_r2_present_sticky: assert property (@(posedge clk) disable iff (rst)
    present |=> present);

  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(present && not_found));

  a_r10_state_at_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwr_on) |-> $fell(busy));

  a_r12_busy_cover: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> busy);
endmodule

bind dpwr_seq_top dpwr_seq_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .eng_req   (eng_req),
  .eng_op    (eng_op),
  .eng_addr  (eng_addr),
  .eng_wdata (eng_wdata),
  .eng_done  (eng_done),
  .busy      (busy),
  .present   (present),
  .not_found (not_found),
  .pwr_on    (pwr_on)
);

// File: tb/dpwr_seq_top_tb_top.sv
`timescale 1ns/1ps
module dpwr_seq_top_tb_top;
  localparam int CPM = 8;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_req = 1'b0;
  logic        pwr_req_on = 1'b0;
  logic        eng_req;
  logic [1:0]  eng_op;
  logic [7:0]  eng_addr;
  logic [15:0] eng_wdata;
  logic        eng_done = 1'b0;
  logic [15:0] eng_rdata = 16'h0000;
  logic        busy, present, not_found, pwr_on;

  logic [15:0] id_val = 16'h9220;
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  int          busy_fall = 0;

  logic [25:0] got_q[$];
  int          req_t[$];
  int          done_t[$];
  logic [25:0] exp_q[$];
  int          exp_ms[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpwr_seq_top #(.CLKS_PER_MS(CPM), .MS_W(8)) dut_i (
    .clk(clk), .rst(rst), .pwr_req(pwr_req), .pwr_req_on(pwr_req_on),
    .eng_req(eng_req), .eng_op(eng_op), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_rdata(eng_rdata),
    .busy(busy), .present(present), .not_found(not_found), .pwr_on(pwr_on)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // engine model: answers each request after LAT cycles
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && eng_req) begin
        got_q.push_back({eng_op, eng_addr, eng_wdata});
        req_t.push_back(cyc);
        repeat (LAT - 1) @(negedge clk);
        eng_rdata = id_val;
        eng_done  = 1'b1;
        done_t.push_back(cyc);
        @(negedge clk);
        eng_done = 1'b0;
        chk(eng_req == 1'b0, "R5", "request dropped after done", eng_req, 0);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", cyc, 190000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [25:0] tx(input logic [1:0] op, input logic [7:0] a,
                                     input logic [15:0] d);
    return {op, a, d};
  endfunction

  task automatic add(input logic [1:0] op, input logic [7:0] a,
                     input logic [15:0] d, input int ms_before);
    exp_q.push_back(tx(op, a, d));
    exp_ms.push_back(ms_before);
  endtask

  task automatic clear_all();
    got_q.delete(); req_t.delete(); done_t.delete();
    exp_q.delete(); exp_ms.delete();
  endtask

  // R7 off list; lead_ms is the pause before its first write
  task automatic add_off(input int lead_ms);
    add(2'b01, 8'h10, 16'h0000, lead_ms);
    add(2'b01, 8'h11, 16'h0000, 10);
    add(2'b01, 8'h12, 16'h0000, 0);
    add(2'b01, 8'h13, 16'h0000, 40);
  endtask

  // R8 on list
  task automatic add_on(input int lead_ms);
    add_off(lead_ms);
    add(2'b01, 8'h56, 16'h080F, 40);
    add(2'b01, 8'h10, 16'h4240, 0);
    add(2'b01, 8'h11, 16'h0000, 10);
    add(2'b01, 8'h12, 16'h0014, 0);
    add(2'b01, 8'h13, 16'h1319, 40);
  endtask

  task automatic add_init();
    add(2'b10, 8'h00, 16'h0000, 0);
    add(2'b01, 8'h00, 16'h0001, 0);
    add(2'b01, 8'h0C, 16'h0110, 10);
    add_on(0);
    add(2'b00, 8'h22, 16'h0000, 40);
  endtask

  task automatic do_reset(input logic [15:0] id);
    id_val = id;
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse(input logic on);
    @(negedge clk);
    pwr_req = 1'b1;
    pwr_req_on = on;
    @(negedge clk);
    pwr_req = 1'b0;
  endtask

  task automatic wait_all(input int n);
    while (got_q.size() < n) @(negedge clk);
    while (busy) @(negedge clk);
    busy_fall = cyc;
    repeat (10) @(negedge clk);
  endtask

  task automatic compare_run(input string tag);
    chk(got_q.size() == exp_q.size(), tag, "operation count",
        got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      int gap;
      chk(got_q[i] == exp_q[i], tag, $sformatf("operation %0d", i),
          got_q[i], exp_q[i]);
      if (i > 0 && exp_ms[i] > 0) begin
        gap = req_t[i] - done_t[i-1];
        chk(gap >= exp_ms[i] * CPM && gap <= exp_ms[i] * CPM + 16, "R6",
            $sformatf("pause before operation %0d", i), gap, exp_ms[i] * CPM);
      end
    end
  endtask

  task automatic check_tail_wait();
    int gap;
    gap = busy_fall - done_t[done_t.size() - 1];
    chk(gap >= 40 * CPM, "R6", "closing 40 ms pause", gap, 40 * CPM);
  endtask

  initial begin
    // sweep every accepted ID
    for (int n = 0; n < 16; n++) begin
      clear_all();
      add_init();
      do_reset(16'h9220 | 16'(n));
      chk(busy && !present && !not_found && !pwr_on, "R1", "state after reset",
          {busy, present, not_found, pwr_on}, 4'b1000);
      wait_all(exp_q.size());
      chk(present && !not_found, "R2", $sformatf("id %0h accepted", id_val),
          {present, not_found}, 2'b10);
      chk(pwr_on && !busy, "R4", "powered and idle after init",
          {pwr_on, busy}, 2'b10);
      compare_run(n == 0 ? "R1" : "R4");
    end

    // near-miss IDs are rejected
    for (int k = 0; k < 8; k++) begin
      logic [15:0] bad;
      case (k)
        0: bad = 16'h9230;
        1: bad = 16'h9210;
        2: bad = 16'h92A0;
        3: bad = 16'h1220;
        4: bad = 16'h0000;
        5: bad = 16'hFFFF;
        6: bad = 16'h9320;
        default: bad = 16'hA220;
      endcase
      clear_all();
      do_reset(bad);
      while (busy) @(negedge clk);
      repeat (5) @(negedge clk);
      chk(not_found && !present && !pwr_on, "R2", $sformatf("id %0h rejected", bad),
          {not_found, present, pwr_on}, 3'b100);
      pulse(1'b1);
      repeat (60) @(negedge clk);
      chk(got_q.size() == 1 && !busy && !pwr_on, "R3", "halted after reject",
          got_q.size(), 1);
    end

    // power transitions
    clear_all();
    add_init();
    do_reset(16'h9222);
    wait_all(exp_q.size());

    clear_all();
    pulse(1'b1);
    repeat (30) @(negedge clk);
    chk(got_q.size() == 0 && !busy && pwr_on, "R9", "on while on skipped",
        got_q.size(), 0);

    clear_all();
    add_off(0);
    pulse(1'b0);
    repeat (12) @(negedge clk);
    chk(busy == 1'b1, "R12", "busy during off", busy, 1);
    chk(pwr_on == 1'b1, "R10", "state held during off", pwr_on, 1);
    wait_all(exp_q.size());
    chk(pwr_on == 1'b0, "R7", "off after off sequence", pwr_on, 0);
    compare_run("R7");
    check_tail_wait();

    clear_all();
    pulse(1'b0);
    repeat (30) @(negedge clk);
    chk(got_q.size() == 0 && !busy && !pwr_on, "R9", "off while off skipped",
        got_q.size(), 0);

    clear_all();
    add_on(0);
    pulse(1'b1);
    repeat (12) @(negedge clk);
    chk(pwr_on == 1'b0 && busy, "R10", "state held during on",
        {pwr_on, busy}, 2'b01);
    wait_all(exp_q.size());
    chk(pwr_on == 1'b1, "R8", "on after on sequence", pwr_on, 1);
    compare_run("R8");
    check_tail_wait();

    // off then a held on request
    clear_all();
    add_off(0);
    add_on(40);
    pulse(1'b0);
    repeat (30) @(negedge clk);
    pulse(1'b1);
    wait_all(exp_q.size());
    chk(pwr_on == 1'b1, "R11", "held on request ran", pwr_on, 1);
    compare_run("R11");

    // held on replaced by a later off; the off is then redundant
    clear_all();
    add_off(0);
    pulse(1'b0);
    repeat (30) @(negedge clk);
    pulse(1'b1);
    repeat (5) @(negedge clk);
    pulse(1'b0);
    wait_all(exp_q.size());
    repeat (40) @(negedge clk);
    chk(pwr_on == 1'b0 && !busy, "R11", "latest held request wins",
        {pwr_on, busy}, 2'b00);
    compare_run("R11");

    // off request during initialisation is held until init ends
    clear_all();
    add_init();
    add_off(0);
    do_reset(16'h9221);
    repeat (20) @(negedge clk);
    pulse(1'b0);
    wait_all(exp_q.size());
    chk(pwr_on == 1'b0 && present, "R11", "off held through init",
        {pwr_on, present}, 2'b01);
    compare_run("R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule